// File: doc/BRIEF.md
# Paired Q15 Rounding Saturating Multiplier

This datapath block takes two 32-bit source words. Each word carries two packed signed Q15 halfword lanes. Matching lanes are multiplied as signed fractions and the product is doubled. It is then rounded to nearest by adding half of a result LSB and truncated back to Q15. The two lane results are packed into one 32-bit destination word. The single product that Q15 cannot represent, minus one times minus one, is clamped to the largest positive value. Any such clamp raises a per-operation overflow indication and sets a sticky status bit.

A mode input selects a wide variant. It multiplies only the low lane pair and returns the full doubled Q31 product across the whole destination word, with the same clamp for minus one times minus one. The block has one register stage. An operation presented with the valid strobe appears on the outputs on the next clock edge, together with its flags. Software clears the sticky bit through a dedicated clear input. After a clear, the bit reports only saturations that occurred since that clear.

Top module: `q15_pair_mul`

## Requirements
- R1: In pair mode, each lane result equals bits 31:16 of (2 × signed product of the two 16-bit lane operands + 0x00008000). Operands are two's complement. For example, 0x80011234 × 0x80024321 gives 0x7FFD098C with no overflow.
- R2: Result bits 31:16 depend only on operand bits 31:16 and result bits 15:0 depend only on operand bits 15:0. The lanes are independent.
- R3: In pair mode, a lane whose two operands are both 0x8000 yields 0x7FFF. The other lane is unaffected.
- R4: The per-operation overflow output is 1 exactly when at least one lane of that operation saturated (pair mode) or the wide product saturated (wide mode). Otherwise it is 0.
- R5: The sticky overflow bit becomes 1 in the same cycle as the result of any saturating operation. Once set, it stays 1 until it is cleared.
- R6: A clear pulse sets the sticky bit to 0 on the next edge. If a saturating operation completes on the same edge as the clear, the bit ends up 1.
- R7: With mode_full = 1, the result is 2 × (signed op_a[15:0] × signed op_b[15:0]) as a 32-bit Q31 value. When both low operands are 0x8000, the result is 0x7FFFFFFF and overflow is raised. The upper operand halves are ignored.
- R8: res_valid is 1 exactly one cycle after in_valid. result and ovf change only on cycles after in_valid and hold otherwise.
- R9: After reset, res_valid, result, ovf and sticky_ovf are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe; operands and mode are sampled when high |
| mode_full | input | 1 | 0: paired Q15 multiply, 1: wide Q31 multiply of the low lanes |
| op_a | input | 32 | First source word, two Q15 lanes |
| op_b | input | 32 | Second source word, two Q15 lanes |
| sticky_clr | input | 1 | Clears the sticky overflow bit |
| res_valid | output | 1 | Result of an operation is present |
| result | output | 32 | Packed Q15 pair or Q31 product |
| ovf | output | 1 | Saturation occurred in the reported operation |
| sticky_ovf | output | 1 | Accumulated saturation status |

## Verification
Suppose the product logic treated lane operands as unsigned, or swapped lanes. The first operation with a negative operand would then put a wrong halfword on result, visible one cycle after its strobe. A sticky bit that dropped on its own, ignored a clear, or lost a same-edge set would show on sticky_ovf at the first idle or clearing cycle after the saturation. The bench therefore checks the sticky bit after every operation and across idle gaps. A broken clamp shows as 0x8000 (or 0x80000000) instead of the maximum value on the very next result.

// File: rtl/q15_mul_pkg.sv
package q15_mul_pkg;
  localparam int unsigned LANE_W_DEF = 16;
  localparam int unsigned LANES_DEF  = 2;

  typedef enum logic {
    MODE_PAIR_Q15 = 1'b0,
    MODE_WIDE_Q31 = 1'b1
  } mul_mode_e;
endpackage

// File: rtl/q15_lane_mul.sv
module q15_lane_mul #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   q_rnd,
  output logic [2*W-1:0] q_wide,
  output logic           sat
);
  localparam int unsigned PW = 2 * W;
  localparam logic [W-1:0]  NEG_ONE  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0]  MAX_NARROW = {1'b0, {(W-1){1'b1}}};
  localparam logic [PW-1:0] MAX_WIDE = {1'b0, {(PW-1){1'b1}}};
  localparam logic [PW:0]   HALF_LSB = (PW+1)'(1) << (W-1);

  logic signed [PW-1:0] ext_a;
  logic signed [PW-1:0] ext_b;
  logic signed [PW-1:0] prod;
  logic [PW-1:0]        dbl;
  logic [PW:0]          rnd_sum;

  always_comb begin
    ext_a   = signed'({{W{a[W-1]}}, a});
    ext_b   = signed'({{W{b[W-1]}}, b});
    prod    = ext_a * ext_b;
    dbl     = prod << 1;
    rnd_sum = {dbl[PW-1], dbl} + HALF_LSB;
    sat     = (a == NEG_ONE) && (b == NEG_ONE);
    q_rnd   = sat ? MAX_NARROW : rnd_sum[PW-1:W];
    q_wide  = sat ? MAX_WIDE : dbl;
  end

  // R1: rounding never carries past the sign of the doubled product
  always_comb begin
    if (!sat) begin
      p_no_round_carry_r1: assert (rnd_sum[PW] == rnd_sum[PW-1])
        else $error("rounding carried out of the product");
    end
  end
endmodule

// File: rtl/q15_sticky_flag.sv
module q15_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = set_i | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R5: without a clear the bit never falls
  p_sticky_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr_i |=> flag_q);
  // R6: a set always wins on its edge
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
  // R6: clear with no set empties the bit
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !set_i |=> !flag_q);
endmodule

// File: rtl/q15_pair_mul.sv
module q15_pair_mul
  import q15_mul_pkg::*;
#(
  parameter int unsigned LANE_W = LANE_W_DEF,
  parameter int unsigned LANES  = LANES_DEF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      mode_full,
  input  logic [LANES*LANE_W-1:0]   op_a,
  input  logic [LANES*LANE_W-1:0]   op_b,
  input  logic                      sticky_clr,
  output logic                      res_valid,
  output logic [LANES*LANE_W-1:0]   result,
  output logic                      ovf,
  output logic                      sticky_ovf
);
  localparam int unsigned DATA_W = LANES * LANE_W;
  localparam int unsigned WIDE_W = 2 * LANE_W;
  localparam logic [LANE_W-1:0] NEG_ONE = {1'b1, {(LANE_W-1){1'b0}}};

  logic [DATA_W-1:0]  pair_res;
  logic [LANES-1:0]   lane_sat;
  logic [WIDE_W-1:0]  lane_wide [LANES];
  mul_mode_e          mode;

  logic [DATA_W-1:0]  result_d, result_q;
  logic               ovf_d, ovf_q;
  logic               vld_q;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      q15_lane_mul #(.W(LANE_W)) u_lane (
        .a      (op_a[g*LANE_W +: LANE_W]),
        .b      (op_b[g*LANE_W +: LANE_W]),
        .q_rnd  (pair_res[g*LANE_W +: LANE_W]),
        .q_wide (lane_wide[g]),
        .sat    (lane_sat[g])
      );
    end
  endgenerate

  always_comb begin
    mode = mul_mode_e'(mode_full);
    if (mode == MODE_WIDE_Q31) begin
      result_d = DATA_W'(lane_wide[0]);
      ovf_d    = lane_sat[0];
    end else begin
      result_d = pair_res;
      ovf_d    = |lane_sat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      ovf_q    <= 1'b0;
    end else if (in_valid) begin
      result_q <= result_d;
      ovf_q    <= ovf_d;
    end
  end

  q15_sticky_flag u_sticky (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (in_valid & ovf_d),
    .clr_i  (sticky_clr),
    .flag_o (sticky_ovf)
  );

  assign res_valid = vld_q;
  assign result    = result_q;
  assign ovf       = ovf_q;

  // R8: one-cycle latency and holding while idle
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result) && $stable(ovf) && !res_valid);
  // R3: low lane clamp in pair mode
  p_sat_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !mode_full && op_a[LANE_W-1:0] == NEG_ONE && op_b[LANE_W-1:0] == NEG_ONE
    |=> result[LANE_W-1:0] == {1'b0, {(LANE_W-1){1'b1}}} && ovf);
  // R7: wide clamp
  p_sat_wide_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode_full && op_a[LANE_W-1:0] == NEG_ONE && op_b[LANE_W-1:0] == NEG_ONE
    |=> result[WIDE_W-1:0] == {1'b0, {(WIDE_W-1){1'b1}}} && ovf);
  // R5: a reported overflow is always reflected in the sticky bit
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && ovf |-> sticky_ovf);
endmodule

// File: tb/q15_pair_mul_tb.sv
module q15_pair_mul_tb;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        mode_full;
  logic [31:0] op_a;
  logic [31:0] op_b;
  logic        sticky_clr;
  logic        res_valid;
  logic [31:0] result;
  logic        ovf;
  logic        sticky_ovf;

  int checks;
  int errors;
  logic model_sticky;

  q15_pair_mul u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_full(mode_full),
    .op_a(op_a), .op_b(op_b), .sticky_clr(sticky_clr),
    .res_valid(res_valid), .result(result), .ovf(ovf), .sticky_ovf(sticky_ovf)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [15:0] ref_lane(input logic [15:0] a, input logic [15:0] b);
    int p;
    int s;
    if (a == 16'h8000 && b == 16'h8000) return 16'h7FFF;
    p = int'($signed(a)) * int'($signed(b));
    s = p * 2 + 32'h8000;
    return s[31:16];
  endfunction

  function automatic logic ref_lane_sat(input logic [15:0] a, input logic [15:0] b);
    return (a == 16'h8000) && (b == 16'h8000);
  endfunction

  function automatic logic [31:0] ref_wide(input logic [15:0] a, input logic [15:0] b);
    int p;
    if (a == 16'h8000 && b == 16'h8000) return 32'h7FFFFFFF;
    p = int'($signed(a)) * int'($signed(b));
    return 32'(p * 2);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one operation, then sample its result one cycle later
  task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                        input logic wide, input logic clr);
    logic [31:0] exp_r;
    logic        exp_o;
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b; mode_full = wide; sticky_clr = clr;
    if (wide) begin
      exp_r = ref_wide(a[15:0], b[15:0]);
      exp_o = ref_lane_sat(a[15:0], b[15:0]);
    end else begin
      exp_r = {ref_lane(a[31:16], b[31:16]), ref_lane(a[15:0], b[15:0])};
      exp_o = ref_lane_sat(a[31:16], b[31:16]) | ref_lane_sat(a[15:0], b[15:0]);
    end
    model_sticky = exp_o | (model_sticky & ~clr);
    @(negedge clk);
    in_valid = 1'b0; sticky_clr = 1'b0;
    check({req, " result"}, result, exp_r);
    check({req, " ovf"}, 32'(ovf), 32'(exp_o));
    check({req, " valid R8"}, 32'(res_valid), 32'd1);
    check({req, " sticky R5"}, 32'(sticky_ovf), 32'(model_sticky));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] hold_r;
    checks = 0; errors = 0; model_sticky = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; mode_full = 1'b0;
    op_a = '0; op_b = '0; sticky_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 valid", 32'(res_valid), 32'd0);
    check("R9 result", result, 32'd0);
    check("R9 ovf", 32'(ovf), 32'd0);
    check("R9 sticky", 32'(sticky_ovf), 32'd0);

    // R1 known vector
    run_op("R1 example", 32'h80011234, 32'h80024321, 1'b0, 1'b0);
    check("R1 literal", result, 32'h7FFD098C);
    // R1 sign combinations
    run_op("R1 pos*pos", 32'h40003000, 32'h20001234, 1'b0, 1'b0);
    run_op("R1 pos*neg", 32'h4000C000, 32'hC0003000, 1'b0, 1'b0);
    run_op("R1 neg*neg", 32'hC000F000, 32'hA000FFFF, 1'b0, 1'b0);
    run_op("R1 neg*pos", 32'hFFFF8001, 32'h00017FFF, 1'b0, 1'b0);
    run_op("R1 8000x8001", 32'h80008001, 32'h80018000, 1'b0, 1'b0);
    check("R4 no sat on near pair", 32'(ovf), 32'd0);
    // R2 lane independence: changing high lane keeps low lane
    run_op("R2 base", 32'h12345678, 32'h0ABC7654, 1'b0, 1'b0);
    hold_r = result;
    run_op("R2 swap high", 32'hF0005678, 32'h77777654, 1'b0, 1'b0);
    check("R2 low lane unchanged", 32'(result[15:0]), 32'(hold_r[15:0]));
    // R3 saturation, single lane then both lanes
    run_op("R3 low sat", 32'h20008000, 32'h30008000, 1'b0, 1'b0);
    check("R3 low lane 7FFF", 32'(result[15:0]), 32'h7FFF);
    run_op("R3 both sat", 32'h80008000, 32'h80008000, 1'b0, 1'b0);
    check("R3 both 7FFF", result, 32'h7FFF7FFF);
    check("R4 ovf both", 32'(ovf), 32'd1);
    // R5 sticky survives idle cycles and non-saturating ops
    repeat (4) @(negedge clk);
    check("R5 sticky idle", 32'(sticky_ovf), 32'd1);
    run_op("R5 clean op", 32'h11112222, 32'h33334444, 1'b0, 1'b0);
    check("R5 sticky kept", 32'(sticky_ovf), 32'd1);
    // R6 clear alone
    @(negedge clk); sticky_clr = 1'b1;
    @(negedge clk); sticky_clr = 1'b0;
    check("R6 cleared", 32'(sticky_ovf), 32'd0);
    model_sticky = 1'b0;
    // R6 clear with a saturating op on the same edge
    run_op("R6 clr+sat", 32'h80000001, 32'h80000001, 1'b0, 1'b1);
    check("R6 set wins", 32'(sticky_ovf), 32'd1);
    run_op("R6 clr+clean", 32'h00010001, 32'h00010001, 1'b0, 1'b1);
    check("R6 clear with clean op", 32'(sticky_ovf), 32'd0);
    // R7 wide mode
    run_op("R7 wide", 32'hFFFF8001, 32'h12348001, 1'b1, 1'b0);
    check("R7 wide literal", result, 32'h7FFE0002);
    run_op("R7 wide sat", 32'h00008000, 32'h7FFF8000, 1'b1, 1'b0);
    check("R7 wide 7FFFFFFF", result, 32'h7FFFFFFF);
    run_op("R7 wide neg", 32'h00004000, 32'h0000C000, 1'b1, 1'b0);
    // R8 hold while idle with changing inputs
    hold_r = result;
    @(negedge clk); op_a = 32'h80008000; op_b = 32'h80008000; mode_full = 1'b0;
    @(negedge clk);
    check("R8 result held", result, hold_r);
    check("R8 valid low", 32'(res_valid), 32'd0);

    // random vectors, with forced corner lanes mixed in
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom; rb = $urandom;
      if ((i % 17) == 0) begin ra[15:0] = 16'h8000; rb[15:0] = 16'h8000; end
      if ((i % 23) == 0) begin ra[31:16] = 16'h8000; rb[31:16] = 16'h8000; end
      run_op("R1 random", ra, rb, (i % 5) == 0, (i % 11) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule